// File: doc/BRIEF.md
# Queue Level Flag Bus Monitor

This block watches the fill level of every queue in a multi-queue buffer and presents two active-low status buses: one almost-full bus and one almost-empty bus. Each bus has one bit per queue. Every queue is reported on every cycle, whether or not it is the queue selected on the write side or the read side. The buffer core supplies the per-queue word counts, capacities and threshold offsets. This block only compares those values and registers the results. The almost-full side runs on the write clock and the almost-empty side runs on the read clock.

Several devices can share one pair of buses. Each device has an identity number. In rotating mode, an owner selector advances by one device on every clock edge and wraps after the last device. In addressed mode, the owner is a device number loaded from an address input. The almost-full bus is addressed from the write side and the almost-empty bus from the read side, and the two are independent. For each bus, the block outputs the flag values together with a drive enable that is high when this device owns the bus. Pad logic outside the block uses that enable.

Top module: `qfm_flag_monitor`

## Requirements
- R1: Almost-full bus bit q is low (asserted) after a write-clock edge exactly when queue q is configured and its free space at that edge (capacity minus write-side count, floored at 0) is at or below its almost-full offset. Bit q sits at position q.
- R2: Almost-empty bus bit q is low after a read-clock edge exactly when queue q is configured and its read-side count at that edge is at or below its almost-empty offset.
- R3: Queue q is configured when q < `cfg_nq`. Bits of unconfigured queues are driven high on both buses, so `cfg_nq`=0 gives all ones.
- R4: The almost-full bus and its drive enable change only on write-clock edges. The almost-empty bus and its drive enable change only on read-clock edges. When one clock stops, its bus holds while the other bus keeps updating.
- R5: With `poll_mode`=1, each edge of the bus's clock advances the owner selector by one. After device `dev_last` it wraps to 0. The first such edge after reset selects device 0. The drive enable is high after an edge exactly when the selector lands on `dev_id`. With `dev_last`=0, the drive enable stays high for device 0.
- R6: A device number on the select address is captured at an edge where its valid input is high, and the captured number is kept while valid is low. With `poll_mode`=0, the drive enable after an edge is high exactly when the captured number equals `dev_id`.
- R7: The almost-full owner is taken only from the write-side select inputs and the almost-empty owner only from the read-side select inputs. Loading one has no effect on the other's drive enable.
- R8: While a domain's reset is high, its bus is all ones and its drive enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst | input | 1 | Write-side synchronous reset, active high |
| rclk | input | 1 | Read-side clock |
| rrst | input | 1 | Read-side synchronous reset, active high |
| poll_mode | input | 1 | 1 = rotating ownership, 0 = addressed ownership |
| dev_id | input | 3 | Identity of this device |
| dev_last | input | 3 | Highest device number sharing the buses |
| cfg_nq | input | $clog2(NQ+1) | Number of configured queues |
| q_cap | input | NQ*CNT_W | Capacity of each queue in words, queue q at slice q |
| wr_cnt | input | NQ*CNT_W | Write-side word count of each queue |
| rd_cnt | input | NQ*CNT_W | Read-side word count of each queue |
| af_off | input | NQ*CNT_W | Almost-full offset of each queue |
| ae_off | input | NQ*CNT_W | Almost-empty offset of each queue |
| af_sel_vld | input | 1 | Load the almost-full owner address |
| af_sel_addr | input | 3 | Almost-full owner device number |
| ae_sel_vld | input | 1 | Load the almost-empty owner address |
| ae_sel_addr | input | 3 | Almost-empty owner device number |
| af_bus_n | output | NQ | Almost-full flags, active low |
| af_drive | output | 1 | This device owns the almost-full bus |
| ae_bus_n | output | NQ | Almost-empty flags, active low |
| ae_drive | output | 1 | This device owns the almost-empty bus |

## Verification
Two things can happen on the same edge: a flag update and a change of bus ownership. The bench makes them coincide by changing counts and owner inputs at the same negative edge. It then checks that the flag bits and the drive enable move together after exactly one rising edge. A second clash is between the domains. The read clock is gated off while write-side counts, read-side counts and the read-side address all change. The almost-full bus must update while the almost-empty bus and its enable hold, until the read clock resumes.

// File: rtl/qfm_pkg.sv
`timescale 1ns/1ps
package qfm_pkg;
  // Up to eight devices can share the status buses.
  localparam int DEV_W = 3;
  typedef logic [DEV_W-1:0] dev_t;
endpackage

// File: rtl/qfm_flag_reg.sv
`timescale 1ns/1ps
// Registered per-queue threshold compare, one active-low bit per queue.
module qfm_flag_reg #(
  parameter int NQ    = 4,
  parameter int CNT_W = 8,
  localparam int QN_W = $clog2(NQ + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [QN_W-1:0]       cfg_nq,
  input  logic [NQ*CNT_W-1:0]   level,
  input  logic [NQ*CNT_W-1:0]   thr,
  output logic [NQ-1:0]         bus_n
);
  logic [NQ-1:0] hit;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    always_comb begin
      hit[q] = (cfg_nq > QN_W'(q)) &&
               (level[q*CNT_W +: CNT_W] <= thr[q*CNT_W +: CNT_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_n <= '1;
    else     bus_n <= ~hit;
  end
endmodule

// File: rtl/qfm_bus_owner.sv
`timescale 1ns/1ps
// Decides whether this device drives a shared bus: rotating or addressed.
module qfm_bus_owner
  import qfm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic poll_mode,
  input  dev_t dev_id,
  input  dev_t dev_last,
  input  logic sel_vld,
  input  dev_t sel_addr,
  output logic drive
);
  dev_t poll_q, poll_nxt, dir_q, dir_nxt, owner;

  always_comb begin
    poll_nxt = poll_q;
    if (poll_mode) poll_nxt = (poll_q >= dev_last) ? '0 : poll_q + 1'b1;
    dir_nxt  = sel_vld ? sel_addr : dir_q;
    owner    = poll_mode ? poll_nxt : dir_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      poll_q <= '1;  // first rotating edge wraps to device 0
      dir_q  <= '0;
      drive  <= 1'b0;
    end else begin
      poll_q <= poll_nxt;
      dir_q  <= dir_nxt;
      drive  <= (owner == dev_id);
    end
  end
endmodule

// File: rtl/qfm_flag_monitor.sv
`timescale 1ns/1ps
module qfm_flag_monitor
  import qfm_pkg::*;
#(
  parameter int NQ    = 4,
  parameter int CNT_W = 8,
  localparam int QN_W = $clog2(NQ + 1)
) (
  input  logic                wclk,
  input  logic                wrst,
  input  logic                rclk,
  input  logic                rrst,
  input  logic                poll_mode,
  input  logic [DEV_W-1:0]    dev_id,
  input  logic [DEV_W-1:0]    dev_last,
  input  logic [QN_W-1:0]     cfg_nq,
  input  logic [NQ*CNT_W-1:0] q_cap,
  input  logic [NQ*CNT_W-1:0] wr_cnt,
  input  logic [NQ*CNT_W-1:0] rd_cnt,
  input  logic [NQ*CNT_W-1:0] af_off,
  input  logic [NQ*CNT_W-1:0] ae_off,
  input  logic                af_sel_vld,
  input  logic [DEV_W-1:0]    af_sel_addr,
  input  logic                ae_sel_vld,
  input  logic [DEV_W-1:0]    ae_sel_addr,
  output logic [NQ-1:0]       af_bus_n,
  output logic                af_drive,
  output logic [NQ-1:0]       ae_bus_n,
  output logic                ae_drive
);
  logic [NQ*CNT_W-1:0] free_sp;

  // Free space per queue, floored at zero.
  for (genvar q = 0; q < NQ; q++) begin : g_free
    logic [CNT_W-1:0] cap, cnt;
    always_comb begin
      cap = q_cap[q*CNT_W +: CNT_W];
      cnt = wr_cnt[q*CNT_W +: CNT_W];
      free_sp[q*CNT_W +: CNT_W] = (cap >= cnt) ? cap - cnt : '0;
    end
  end

  qfm_flag_reg #(.NQ(NQ), .CNT_W(CNT_W)) u_af_flags (
    .clk(wclk), .rst(wrst), .cfg_nq(cfg_nq),
    .level(free_sp), .thr(af_off), .bus_n(af_bus_n)
  );

  qfm_flag_reg #(.NQ(NQ), .CNT_W(CNT_W)) u_ae_flags (
    .clk(rclk), .rst(rrst), .cfg_nq(cfg_nq),
    .level(rd_cnt), .thr(ae_off), .bus_n(ae_bus_n)
  );

  qfm_bus_owner u_af_owner (
    .clk(wclk), .rst(wrst), .poll_mode(poll_mode), .dev_id(dev_id),
    .dev_last(dev_last), .sel_vld(af_sel_vld), .sel_addr(af_sel_addr),
    .drive(af_drive)
  );

  qfm_bus_owner u_ae_owner (
    .clk(rclk), .rst(rrst), .poll_mode(poll_mode), .dev_id(dev_id),
    .dev_last(dev_last), .sel_vld(ae_sel_vld), .sel_addr(ae_sel_addr),
    .drive(ae_drive)
  );
endmodule

// File: rtl/qfm_flag_monitor_chk.sv
`timescale 1ns/1ps
module qfm_flag_monitor_chk #(
  parameter int NQ    = 4,
  parameter int CNT_W = 8,
  localparam int QN_W = $clog2(NQ + 1)
) (
  input logic                wclk,
  input logic                wrst,
  input logic                rclk,
  input logic                rrst,
  input logic                poll_mode,
  input logic [2:0]          dev_id,
  input logic [2:0]          dev_last,
  input logic [QN_W-1:0]     cfg_nq,
  input logic [NQ*CNT_W-1:0] q_cap,
  input logic [NQ*CNT_W-1:0] wr_cnt,
  input logic [NQ*CNT_W-1:0] rd_cnt,
  input logic [NQ*CNT_W-1:0] af_off,
  input logic [NQ*CNT_W-1:0] ae_off,
  input logic                af_sel_vld,
  input logic [2:0]          af_sel_addr,
  input logic                ae_sel_vld,
  input logic [2:0]          ae_sel_addr,
  input logic [NQ-1:0]       af_bus_n,
  input logic                af_drive,
  input logic [NQ-1:0]       ae_bus_n,
  input logic                ae_drive
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    assert_af_unused_high_R3: assert property (@(posedge wclk) disable iff (wrst)
      ($past(cfg_nq) <= QN_W'(q)) |-> af_bus_n[q]);
    assert_ae_unused_high_R3: assert property (@(posedge rclk) disable iff (rrst)
      ($past(cfg_nq) <= QN_W'(q)) |-> ae_bus_n[q]);
    assert_ae_level_R2: assert property (@(posedge rclk) disable iff (rrst)
      !ae_bus_n[q] |-> ($past(rd_cnt[q*CNT_W +: CNT_W]) <= $past(ae_off[q*CNT_W +: CNT_W])));
    assert_af_level_R1: assert property (@(posedge wclk) disable iff (wrst)
      !af_bus_n[q] |-> ($past(q_cap[q*CNT_W +: CNT_W]) <=
                        $past(wr_cnt[q*CNT_W +: CNT_W]) + $past(af_off[q*CNT_W +: CNT_W])));
  end

  assert_af_direct_R6: assert property (@(posedge wclk) disable iff (wrst)
    $past(!wrst && !poll_mode && af_sel_vld) |-> (af_drive == ($past(af_sel_addr) == $past(dev_id))));
  assert_ae_direct_R6: assert property (@(posedge rclk) disable iff (rrst)
    $past(!rrst && !poll_mode && ae_sel_vld) |-> (ae_drive == ($past(ae_sel_addr) == $past(dev_id))));
  assert_af_reset_R8: assert property (@(posedge wclk) wrst |=> (!af_drive && (&af_bus_n)));
  assert_ae_reset_R8: assert property (@(posedge rclk) rrst |=> (!ae_drive && (&ae_bus_n)));
endmodule

bind qfm_flag_monitor qfm_flag_monitor_chk #(.NQ(NQ), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/qfm_flag_monitor_tb.sv
`timescale 1ns/1ps
module qfm_flag_monitor_tb;
  localparam int NQ = 4;
  localparam int CW = 8;

  typedef struct packed {
    logic [2:0]    nq;
    logic [31:0]   wc;   // {q3,q2,q1,q0}
    logic [31:0]   rc;
    logic [3:0]    exp_af;
    logic [3:0]    exp_ae;
  } vec_t;

  // capacity 200 each, AF offset 8 each, AE offsets q0..q3 = 5,10,15,20
  localparam vec_t VEC [6] = '{
    '{3'd4, {8'd0,   8'd0,   8'd0,   8'd0  }, {8'd0,  8'd0,  8'd0,  8'd0  }, 4'b1111, 4'b0000},
    '{3'd4, {8'd100, 8'd200, 8'd191, 8'd192}, {8'd21, 8'd15, 8'd11, 8'd5  }, 4'b1010, 4'b1010},
    '{3'd2, {8'd200, 8'd200, 8'd200, 8'd200}, {8'd0,  8'd0,  8'd0,  8'd0  }, 4'b1100, 4'b1100},
    '{3'd0, {8'd200, 8'd200, 8'd200, 8'd200}, {8'd0,  8'd0,  8'd0,  8'd0  }, 4'b1111, 4'b1111},
    '{3'd1, {8'd0,   8'd0,   8'd0,   8'd193}, {8'd0,  8'd0,  8'd0,  8'd6  }, 4'b1110, 4'b1111},
    '{3'd3, {8'd200, 8'd180, 8'd195, 8'd0  }, {8'd0,  8'd16, 8'd10, 8'd100}, 4'b1101, 4'b1101}
  };

  logic clk = 1'b0;
  logic wclk_run = 1'b1, rclk_run = 1'b1;
  logic wclk, rclk;
  logic wrst, rrst, poll_mode;
  logic [2:0] dev_id, dev_last, af_sel_addr, ae_sel_addr;
  logic [2:0] cfg_nq;
  logic [NQ*CW-1:0] q_cap, wr_cnt, rd_cnt, af_off, ae_off;
  logic af_sel_vld, ae_sel_vld;
  logic [NQ-1:0] af_bus_n, ae_bus_n;
  logic af_drive, ae_drive;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign wclk = clk & wclk_run;
  assign rclk = clk & rclk_run;

  qfm_flag_monitor #(.NQ(NQ), .CNT_W(CW)) u_dut (
    .wclk(wclk), .wrst(wrst), .rclk(rclk), .rrst(rrst), .poll_mode(poll_mode),
    .dev_id(dev_id), .dev_last(dev_last), .cfg_nq(cfg_nq), .q_cap(q_cap),
    .wr_cnt(wr_cnt), .rd_cnt(rd_cnt), .af_off(af_off), .ae_off(ae_off),
    .af_sel_vld(af_sel_vld), .af_sel_addr(af_sel_addr),
    .ae_sel_vld(ae_sel_vld), .ae_sel_addr(ae_sel_addr),
    .af_bus_n(af_bus_n), .af_drive(af_drive), .ae_bus_n(ae_bus_n), .ae_drive(ae_drive)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    wrst = 1; rrst = 1; poll_mode = 1; dev_id = 3'd2; dev_last = 3'd3;
    cfg_nq = 3'd0; wr_cnt = '0; rd_cnt = '0;
    q_cap = {4{8'd200}}; af_off = {4{8'd8}}; ae_off = {8'd20, 8'd15, 8'd10, 8'd5};
    af_sel_vld = 0; ae_sel_vld = 0; af_sel_addr = 0; ae_sel_addr = 0;
    repeat (3) step();
    // R8: reset state
    chk("R8 af bus", {4'b0, af_bus_n}, 8'h0F);
    chk("R8 ae bus", {4'b0, ae_bus_n}, 8'h0F);
    chk("R8 drives", {6'b0, af_drive, ae_drive}, 8'h00);
    wrst = 0; rrst = 0;
    // R5: rotating ownership, 4 devices, this is device 2
    for (int k = 1; k <= 8; k++) begin
      step();
      chk("R5 rotate af", {7'b0, af_drive}, {7'b0, ((k - 1) % 4) == 2});
      chk("R5 rotate ae", {7'b0, ae_drive}, {7'b0, ((k - 1) % 4) == 2});
    end
    // R6/R7: addressed ownership
    poll_mode = 0; af_sel_vld = 1; af_sel_addr = 3'd2; ae_sel_vld = 1; ae_sel_addr = 3'd5;
    step();
    chk("R6 af load own", {7'b0, af_drive}, 8'd1);
    chk("R6 ae load other", {7'b0, ae_drive}, 8'd0);
    af_sel_vld = 0; ae_sel_vld = 0; af_sel_addr = 3'd0; ae_sel_addr = 3'd2;
    step();
    chk("R6 hold af", {7'b0, af_drive}, 8'd1);
    chk("R6 hold ae", {7'b0, ae_drive}, 8'd0);
    ae_sel_vld = 1;
    step();
    chk("R7 ae load", {7'b0, ae_drive}, 8'd1);
    chk("R7 af untouched", {7'b0, af_drive}, 8'd1);
    ae_sel_vld = 0; af_sel_vld = 1; af_sel_addr = 3'd7;
    step();
    chk("R7 af load", {7'b0, af_drive}, 8'd0);
    chk("R7 ae untouched", {7'b0, ae_drive}, 8'd1);
    af_sel_vld = 0;
    // R5: single device, always owner
    poll_mode = 1; dev_last = 3'd0; dev_id = 3'd0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R5 single dev", {6'b0, af_drive, ae_drive}, 8'h03);
    end
    poll_mode = 0; dev_id = 3'd2;
    ae_sel_vld = 1; ae_sel_addr = 3'd2; af_sel_vld = 1; af_sel_addr = 3'd2;
    step();
    ae_sel_vld = 0; af_sel_vld = 0;
    // R1/R2/R3: vector table
    foreach (VEC[i]) begin
      cfg_nq = VEC[i].nq; wr_cnt = VEC[i].wc; rd_cnt = VEC[i].rc;
      step();
      chk($sformatf("R1 R3 af vec%0d", i), {4'b0, af_bus_n}, {4'b0, VEC[i].exp_af});
      chk($sformatf("R2 R3 ae vec%0d", i), {4'b0, ae_bus_n}, {4'b0, VEC[i].exp_ae});
    end
    // R4: read clock stopped, write side keeps updating
    rclk_run = 0;
    cfg_nq = 3'd4; wr_cnt = {4{8'd200}}; rd_cnt = '0; ae_sel_vld = 1; ae_sel_addr = 3'd0;
    step();
    chk("R4 af updates", {4'b0, af_bus_n}, 8'h00);
    chk("R4 ae holds", {4'b0, ae_bus_n}, 8'h0D);
    step();
    chk("R4 ae still holds", {4'b0, ae_bus_n}, 8'h0D);
    chk("R4 ae drive holds", {7'b0, ae_drive}, 8'd1);
    rclk_run = 1;
    step();
    ae_sel_vld = 0;
    chk("R4 ae resumes", {4'b0, ae_bus_n}, 8'h00);
    chk("R4 ae drive resumes", {7'b0, ae_drive}, 8'd0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule